// File: doc/BRIEF.md
# Fixed-Latency Pipelined Load Unit

This block is the load path of a machine whose memory timing is part of the architecture. Software schedules loads knowing that the result arrives at a fixed beat, so the unit has no stall input, no interlock and no ready handshake. A load names a base value and an offset. The offset is either a second register value or a sign-extended immediate of 6, 17 or 32 bits. The unit forms a virtual address, translates its page number through a small fully associative table, reads an internal synchronous RAM and presents the word on a register-file write port.

The path has eight stages, numbered 0 to 7:
- Stage 0 adds the operands.
- Stage 1 translates the address.
- Stage 2 carries the physical address to the memory side.
- Stage 3 starts the RAM read.
- Stage 4 continues the access.
- Stage 5 captures the RAM result.
- Stage 6 moves the data over the load bus.
- Stage 7 drives the write port.

A new load may enter every beat, so up to eight loads are in flight. Each load carries its destination tag. When the page number matches no entry, the unit pulses a miss flag and drops the load.

The translation table and the RAM each have a simple write port. This lets the surrounding logic install mappings and memory contents.

Top module: `ld_pipe_top`

## Requirements
- R1: While reset is high and in the beat after it, `wb_valid_o` and `miss_o` are low. Reset also invalidates every translation entry, so a load issued after reset with no entry installed misses.
- R2: The virtual address is `ld_base_i` plus an offset chosen by `ld_ofs_sel_i`. The codes are: 0 uses `ld_ofs_i`; 1 uses `ld_imm_i[5:0]` sign-extended; 2 uses `ld_imm_i[16:0]` sign-extended; 3 uses all 32 bits of `ld_imm_i`. The addition wraps modulo 2^32. Bits of the immediate outside the selected field, and `ld_ofs_i` when an immediate is selected, have no effect.
- R3: Address bits [7:0] are the word offset within a page and bits [31:8] are the page number. The RAM word read is {physical page, offset}, and that word appears on `wb_data_o`.
- R4: A load sampled at a clock edge with `ld_valid_i` high appears on `wb_valid_o`, with its tag on `wb_tag_o`, for exactly one beat, starting right after the seventh rising edge counted from that sampling edge.
- R5: Loads may be issued on consecutive beats. Each one completes in issue order, with its own tag and data, on consecutive beats.
- R6: A load whose page number matches no valid entry raises `miss_o` for one beat, with its tag on `miss_tag_o`, right after the second edge counted from its sampling edge. That load never produces a `wb_valid_o` beat.
- R7: A table write sampled at an edge sets entry `tlb_idx_i` to map `tlb_vpn_i` to `tlb_ppn_i`, replacing any earlier mapping in that entry. The new mapping applies to a load sampled at the same edge or later.
- R8: When several valid entries match a page number, the entry with the lowest index supplies the physical page.
- R9: A RAM write sampled at the same edge as a load issue, or earlier, is seen by that load.
- R10: In any beat with no completing load, `wb_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Issue a load this beat |
| ld_base_i | input | 32 | Base operand |
| ld_ofs_i | input | 32 | Register offset operand |
| ld_imm_i | input | 32 | Immediate field |
| ld_ofs_sel_i | input | 2 | Offset source: 0 register, 1 imm6, 2 imm17, 3 imm32 |
| ld_tag_i | input | 6 | Destination register tag |
| tlb_we_i | input | 1 | Translation entry write strobe |
| tlb_idx_i | input | 2 | Entry index to write |
| tlb_vpn_i | input | 24 | Virtual page number for the entry |
| tlb_ppn_i | input | 2 | Physical page number for the entry |
| mem_we_i | input | 1 | RAM write strobe |
| mem_waddr_i | input | 10 | RAM word address |
| mem_wdata_i | input | 32 | RAM write data |
| wb_valid_o | output | 1 | Register write strobe (stage 7) |
| wb_tag_o | output | 6 | Register written |
| wb_data_o | output | 32 | Loaded word |
| miss_o | output | 1 | Translation miss pulse |
| miss_tag_o | output | 6 | Tag of the missed load |

## Verification
A stage register that is lost or duplicated shows up at the write port as a beat arriving one cycle early or late, or as a tag paired with the wrong word. The bench compares every beat against a per-cycle schedule, so such a slip shows up within seven beats of the affected issue. A wrong table state, such as a stale, shadowed or mis-prioritised entry, shows up as a wrong word at stage 7 or as a miss pulse out of place at stage 2. Wrong operand selection shows up the same way, because every vector reads a page whose contents are distinct.

// File: rtl/ld_pipe_pkg.sv
package ld_pipe_pkg;
  localparam int LOAD_STAGES = 8;

  typedef enum logic [1:0] {
    OFS_REG   = 2'd0,
    OFS_IMM6  = 2'd1,
    OFS_IMM17 = 2'd2,
    OFS_IMM32 = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/ld_agen.sv
module ld_agen
  import ld_pipe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_base,
  input  logic [DATA_W-1:0] in_ofs,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [1:0]        in_sel,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_va,
  output logic [TAG_W-1:0]  out_tag
);
  // stage 0: operand selection and address sum
  logic [DATA_W-1:0] ofs_mux;

  always_comb begin
    unique case (ofs_sel_e'(in_sel))
      OFS_REG:   ofs_mux = in_ofs;
      OFS_IMM6:  ofs_mux = {{(DATA_W-6){in_imm[5]}}, in_imm[5:0]};
      OFS_IMM17: ofs_mux = {{(DATA_W-17){in_imm[16]}}, in_imm[16:0]};
      default:   ofs_mux = in_imm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_va    <= in_base + ofs_mux;
      out_tag   <= in_tag;
    end
  end
endmodule

// File: rtl/ld_xlate.sv
module ld_xlate #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int POFF_W = 8,
  parameter int PPN_W  = 2,
  parameter int TLB_N  = 4,
  localparam int VPN_W = DATA_W - POFF_W,
  localparam int PA_W  = PPN_W + POFF_W,
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_va,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_pa,
  output logic [TAG_W-1:0]  out_tag,
  output logic              miss_o,
  output logic [TAG_W-1:0]  miss_tag_o
);
  logic [TLB_N-1:0] ent_v;
  logic [VPN_W-1:0] ent_vpn [TLB_N];
  logic [PPN_W-1:0] ent_ppn [TLB_N];
  logic [TLB_N-1:0] hit;
  logic [PPN_W-1:0] sel_ppn;
  logic             any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
    end else if (wr_en) begin
      ent_v[wr_idx]   <= 1'b1;
      ent_vpn[wr_idx] <= wr_vpn;
      ent_ppn[wr_idx] <= wr_ppn;
    end
  end

  // stage 1: parallel compare against every entry
  for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
    assign hit[g] = ent_v[g] && (ent_vpn[g] == in_va[DATA_W-1:POFF_W]);
  end

  assign any_hit = |hit;

  // lowest matching index wins
  always_comb begin
    sel_ppn = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (hit[i]) sel_ppn = ent_ppn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      miss_o    <= 1'b0;
    end else begin
      out_valid  <= in_valid && any_hit;
      miss_o     <= in_valid && !any_hit;
      out_pa     <= {sel_ppn, in_va[POFF_W-1:0]};
      out_tag    <= in_tag;
      miss_tag_o <= in_tag;
    end
  end
endmodule

// File: rtl/ld_ram.sv
module ld_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ld_pipe_top.sv
module ld_pipe_top
  import ld_pipe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int POFF_W = 8,
  parameter int PPN_W  = 2,
  parameter int TLB_N  = 4,
  localparam int VPN_W = DATA_W - POFF_W,
  localparam int PA_W  = PPN_W + POFF_W,
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid_i,
  input  logic [DATA_W-1:0] ld_base_i,
  input  logic [DATA_W-1:0] ld_ofs_i,
  input  logic [DATA_W-1:0] ld_imm_i,
  input  logic [1:0]        ld_ofs_sel_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic              tlb_we_i,
  input  logic [IDX_W-1:0]  tlb_idx_i,
  input  logic [VPN_W-1:0]  tlb_vpn_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic              mem_we_i,
  input  logic [PA_W-1:0]   mem_waddr_i,
  input  logic [DATA_W-1:0] mem_wdata_i,
  output logic              wb_valid_o,
  output logic [TAG_W-1:0]  wb_tag_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              miss_o,
  output logic [TAG_W-1:0]  miss_tag_o
);
  localparam int LAST   = LOAD_STAGES - 1;
  localparam int CAP_ST = 5;

  logic              s1_valid;
  logic [DATA_W-1:0] s1_va;
  logic [TAG_W-1:0]  s1_tag;
  logic              s2_valid;
  logic [PA_W-1:0]   s2_pa;
  logic [TAG_W-1:0]  s2_tag;
  logic              s3_valid;
  logic [PA_W-1:0]   s3_pa;
  logic [TAG_W-1:0]  s3_tag;
  logic              s4_valid;
  logic [TAG_W-1:0]  s4_tag;
  logic [DATA_W-1:0] ram_q;

  logic              dv   [CAP_ST:LAST];
  logic [TAG_W-1:0]  dtag [CAP_ST:LAST];
  logic [DATA_W-1:0] ddat [CAP_ST:LAST];

  ld_agen #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_agen (
    .clk(clk), .rst(rst),
    .in_valid(ld_valid_i), .in_base(ld_base_i), .in_ofs(ld_ofs_i),
    .in_imm(ld_imm_i), .in_sel(ld_ofs_sel_i), .in_tag(ld_tag_i),
    .out_valid(s1_valid), .out_va(s1_va), .out_tag(s1_tag)
  );

  ld_xlate #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .POFF_W(POFF_W),
    .PPN_W(PPN_W), .TLB_N(TLB_N)
  ) u_xlate (
    .clk(clk), .rst(rst),
    .wr_en(tlb_we_i), .wr_idx(tlb_idx_i), .wr_vpn(tlb_vpn_i), .wr_ppn(tlb_ppn_i),
    .in_valid(s1_valid), .in_va(s1_va), .in_tag(s1_tag),
    .out_valid(s2_valid), .out_pa(s2_pa), .out_tag(s2_tag),
    .miss_o(miss_o), .miss_tag_o(miss_tag_o)
  );

  // stage 2: address transport to the memory side
  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0;
    end else begin
      s3_valid <= s2_valid;
      s3_pa    <= s2_pa;
      s3_tag   <= s2_tag;
    end
  end

  // stage 3 starts the read, stage 4 holds the access in flight
  ld_ram #(.DATA_W(DATA_W), .AW(PA_W)) u_ram (
    .clk(clk), .we(mem_we_i), .waddr(mem_waddr_i), .wdata(mem_wdata_i),
    .raddr(s3_pa), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_valid <= 1'b0;
    end else begin
      s4_valid <= s3_valid;
      s4_tag   <= s3_tag;
    end
  end

  // stage 5 captures the RAM result, stages 6 and 7 carry it to the write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = CAP_ST; k <= LAST; k++) dv[k] <= 1'b0;
    end else begin
      dv[CAP_ST]   <= s4_valid;
      dtag[CAP_ST] <= s4_tag;
      ddat[CAP_ST] <= ram_q;
      for (int k = CAP_ST + 1; k <= LAST; k++) begin
        dv[k]   <= dv[k-1];
        dtag[k] <= dtag[k-1];
        ddat[k] <= ddat[k-1];
      end
    end
  end

  assign wb_valid_o = dv[LAST];
  assign wb_tag_o   = dtag[LAST];
  assign wb_data_o  = ddat[LAST];
endmodule

// File: rtl/ld_pipe_chk.sv
module ld_pipe_chk #(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_valid_i,
  input logic [TAG_W-1:0] ld_tag_i,
  input logic             wb_valid_o,
  input logic [TAG_W-1:0] wb_tag_o,
  input logic             miss_o,
  input logic [TAG_W-1:0] miss_tag_o
);
  // R1: outputs quiet in the beat after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wb_valid_o && !miss_o));

  // R4: every write-port beat traces back to an issue seven edges earlier
  p_wb_latency_r4: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> ($past(ld_valid_i, 7) && (wb_tag_o == $past(ld_tag_i, 7))));

  // R6: a miss pulse traces back to an issue two edges earlier
  p_miss_timing_r6: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> ($past(ld_valid_i, 2) && (miss_tag_o == $past(ld_tag_i, 2))));

  // R6: a missed load never reaches the write port
  p_miss_dropped_r6: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> ##5 !wb_valid_o);
endmodule

bind ld_pipe_top ld_pipe_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .ld_valid_i(ld_valid_i), .ld_tag_i(ld_tag_i),
  .wb_valid_o(wb_valid_o), .wb_tag_o(wb_tag_o),
  .miss_o(miss_o), .miss_tag_o(miss_tag_o)
);

// File: tb/tb_ld_pipe_top.sv
`timescale 1ns/1ps
module tb_ld_pipe_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_base_i = '0, ld_ofs_i = '0, ld_imm_i = '0;
  logic [1:0]  ld_ofs_sel_i = '0;
  logic [5:0]  ld_tag_i = '0;
  logic        tlb_we_i = 1'b0;
  logic [1:0]  tlb_idx_i = '0;
  logic [23:0] tlb_vpn_i = '0;
  logic [1:0]  tlb_ppn_i = '0;
  logic        mem_we_i = 1'b0;
  logic [9:0]  mem_waddr_i = '0;
  logic [31:0] mem_wdata_i = '0;
  logic        wb_valid_o, miss_o;
  logic [5:0]  wb_tag_o, miss_tag_o;
  logic [31:0] wb_data_o;

  ld_pipe_top dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_en = 1'b0;
  localparam int HMAX = 4096;
  bit          exp_v [HMAX];
  bit          exp_m [HMAX];
  logic [5:0]  exp_tag [HMAX];
  logic [5:0]  exp_mtag [HMAX];
  logic [31:0] exp_dat [HMAX];
  string       exp_req [HMAX];
  logic [31:0] model [1024];

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] base;
    logic [31:0] ofs;
    logic [31:0] imm;
    logic [5:0]  tag;
    logic        hit;
    logic [9:0]  pa;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'd0, 32'h10,       32'h5,    32'hDEAD,     6'd1,  1'b1, 10'h215},
    '{2'd1, 32'h520,      32'h1234, 32'h3F,       6'd2,  1'b1, 10'h11F},
    '{2'd2, 32'h700,      32'h0,    32'hFFFE0042, 6'd3,  1'b1, 10'h042},
    '{2'd2, 32'h600,      32'h0,    32'h1FF00,    6'd4,  1'b1, 10'h100},
    '{2'd3, 32'h10,       32'h0,    32'hFFFFFF80, 6'd5,  1'b1, 10'h390},
    '{2'd0, 32'h900,      32'h0,    32'h0,        6'd6,  1'b0, 10'h000},
    '{2'd1, 32'h5,        32'h0,    32'h20,       6'd7,  1'b1, 10'h3E5},
    '{2'd0, 32'hFFFFFFFF, 32'h1,    32'h0,        6'd8,  1'b1, 10'h200},
    '{2'd3, 32'h1,        32'h0,    32'h5FF,      6'd9,  1'b0, 10'h000},
    '{2'd0, 32'h7AB,      32'h0,    32'h1234,     6'd10, 1'b1, 10'h0AB},
    '{2'd1, 32'h5FE,      32'h0,    32'hC1,       6'd11, 1'b1, 10'h1FF}
  };

  function automatic logic [31:0] memf(input int a);
    return 32'h5A000000 ^ (a * 32'h00010003);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // per-beat comparison of both output channels against the schedule
  always @(negedge clk) begin
    if (mon_en && cyc < HMAX) begin
      if (exp_v[cyc]) begin
        chk(wb_valid_o === 1'b1, exp_req[cyc], "R4 wb_valid", {63'd0, wb_valid_o}, 64'd1);
        chk(wb_tag_o === exp_tag[cyc], exp_req[cyc], "R5 wb_tag", {58'd0, wb_tag_o}, {58'd0, exp_tag[cyc]});
        chk(wb_data_o === exp_dat[cyc], exp_req[cyc], "R3 wb_data", {32'd0, wb_data_o}, {32'd0, exp_dat[cyc]});
      end else begin
        chk(wb_valid_o === 1'b0, "R10", "idle wb_valid", {63'd0, wb_valid_o}, 64'd0);
      end
      if (exp_m[cyc]) begin
        chk(miss_o === 1'b1, exp_req[cyc], "R6 miss", {63'd0, miss_o}, 64'd1);
        chk(miss_tag_o === exp_mtag[cyc], exp_req[cyc], "R6 miss_tag", {58'd0, miss_tag_o}, {58'd0, exp_mtag[cyc]});
      end else begin
        chk(miss_o === 1'b0, "R6", "spurious miss", {63'd0, miss_o}, 64'd0);
      end
    end
  end

  // called at a negedge; drives one beat and records the expected schedule
  task automatic issue(input logic [1:0] sel, input logic [31:0] base, input logic [31:0] ofs,
                       input logic [31:0] imm, input logic [5:0] tag, input bit hit,
                       input logic [9:0] pa, input string req);
    ld_valid_i = 1'b1; ld_ofs_sel_i = sel; ld_base_i = base;
    ld_ofs_i = ofs; ld_imm_i = imm; ld_tag_i = tag;
    if (hit) begin
      exp_v[cyc+7] = 1'b1; exp_tag[cyc+7] = tag;
      exp_dat[cyc+7] = model[pa]; exp_req[cyc+7] = req;
    end else begin
      exp_m[cyc+2] = 1'b1; exp_mtag[cyc+2] = tag; exp_req[cyc+2] = req;
    end
    @(negedge clk);
    ld_valid_i = 1'b0;
  endtask

  task automatic tlb_wr(input logic [1:0] idx, input logic [23:0] vpn, input logic [1:0] ppn);
    tlb_we_i = 1'b1; tlb_idx_i = idx; tlb_vpn_i = vpn; tlb_ppn_i = ppn;
    @(negedge clk);
    tlb_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(wb_valid_o === 1'b0, "R1", "reset wb_valid", {63'd0, wb_valid_o}, 64'd0);
    chk(miss_o === 1'b0, "R1", "reset miss", {63'd0, miss_o}, 64'd0);
    rst = 1'b0;
    mon_en = 1'b1;
    // R1: table empty after reset, so this load misses
    issue(2'd0, 32'h15, 32'h0, 32'h0, 6'd40, 1'b0, 10'h0, "R1");
    idle(10);

    for (int a = 0; a < 1024; a++) begin
      model[a] = memf(a);
      mem_we_i = 1'b1; mem_waddr_i = 10'(a); mem_wdata_i = model[a];
      @(negedge clk);
    end
    mem_we_i = 1'b0;

    tlb_wr(2'd0, 24'h000000, 2'd2);
    tlb_wr(2'd1, 24'h000005, 2'd1);
    tlb_wr(2'd2, 24'hFFFFFF, 2'd3);
    tlb_wr(2'd3, 24'h000007, 2'd0);
    idle(2);

    // R2 R3 R5: vector table issued back to back
    foreach (VECS[i]) begin
      issue(VECS[i].sel, VECS[i].base, VECS[i].ofs, VECS[i].imm,
            VECS[i].tag, VECS[i].hit, VECS[i].pa, "R2/R5");
    end
    idle(10);

    // R7: overwrite entry 3, page 7 now maps to physical page 1
    tlb_wr(2'd3, 24'h000007, 2'd1);
    issue(2'd0, 32'h742, 32'h0, 32'h0, 6'd20, 1'b1, 10'h142, "R7");
    idle(9);

    // R7: table write at the same edge as the issue applies to that load
    tlb_we_i = 1'b1; tlb_idx_i = 2'd3; tlb_vpn_i = 24'h7; tlb_ppn_i = 2'd3;
    issue(2'd0, 32'h742, 32'h0, 32'h0, 6'd21, 1'b1, 10'h342, "R7");
    tlb_we_i = 1'b0;
    idle(9);

    // R8: two entries map page 9, index 1 wins over index 2
    tlb_wr(2'd2, 24'h000009, 2'd3);
    tlb_wr(2'd1, 24'h000009, 2'd1);
    issue(2'd0, 32'h9AA, 32'h0, 32'h0, 6'd22, 1'b1, 10'h1AA, "R8");
    idle(9);

    // R9: RAM write at the issue edge is seen by the load
    model[10'h215] = 32'hDEADBEEF;
    mem_we_i = 1'b1; mem_waddr_i = 10'h215; mem_wdata_i = 32'hDEADBEEF;
    issue(2'd0, 32'h15, 32'h0, 32'h0, 6'd23, 1'b1, 10'h215, "R9");
    mem_we_i = 1'b0;
    idle(12);

    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule